// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts conditional branches for a fetch unit. A fetch stage offers a branch address on a lookup stream. One cycle after the buffer accepts it, a response carries three things: whether the address is resident, whether to predict taken, and the predicted destination. Storage is 4 ways by 256 sets. Each way keeps a valid flag, an address tag, a destination address and a 2-bit saturating history counter. Each set also keeps per-way age ranks for least-recently-used replacement.

Resolved branches return on a separate update stream. The update carries the branch address, the real outcome and the real destination. A branch earns an entry only the first time it resolves taken, and that entry starts at the strongest taken value. After that, every resolution moves its counter up or down by one, and the counter saturates at both ends.

Back-pressure rules. The lookup stream is accepted only when no response is pending, or when the pending response is being consumed in the same cycle. A response stays valid and unchanged until `rsp_ready` is high. The update stream never stalls: `upd_ready` is high whenever reset is low.

Top module: `btb_core`

## Requirements
- R1: The set index is address bits [7:0] and the tag is bits [31:8]. A lookup hits only when a valid way in the indexed set holds the same tag.
- R2: A lookup miss responds with hit=0, taken=0 and target=0.
- R3: A lookup hit responds with the stored target. It predicts taken when the counter is 2 or 3 and not taken when the counter is 0 or 1.
- R4: A taken update that misses allocates a way. The way gets the update's tag and target, and its counter is set to 3.
- R5: A not-taken update that misses changes nothing: a later lookup of that address still misses.
- R6: A taken update that hits adds one to the counter, saturating at 3. It also replaces the stored target with the update's target.
- R7: A not-taken update that hits subtracts one from the counter, saturating at 0. The stored target is kept.
- R8: Allocation uses the lowest-numbered invalid way of the set. If all four ways are valid, it uses the least recently updated way. Only updates that hit or allocate change recency; lookups do not.
- R9: At most one way of a set ever matches a given tag.
- R10: When a lookup and an update arrive in the same cycle for the same entry, the response reflects the contents before the update.
- R11: The response is valid in the cycle after a lookup is accepted. It holds stable while `rsp_ready` is low, and during that time `lk_ready` is low.
- R12: A synchronous reset invalidates every entry and drops any pending response. After reset, `lk_ready` and `upd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_addr | input | 32 | Branch address to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Address is resident |
| rsp_taken | output | 1 | Predict taken |
| rsp_target | output | 32 | Predicted destination (0 on miss) |
| upd_valid | input | 1 | Resolved branch valid |
| upd_ready | output | 1 | Update accepted (high out of reset) |
| upd_addr | input | 32 | Resolved branch address |
| upd_taken | input | 1 | Real outcome |
| upd_target | input | 32 | Real destination |

## Verification
A lookup that is accepted at a rising edge has its response on the outputs right after that edge. The response is consumed at the next edge where `rsp_ready` is high. An update becomes visible to any lookup accepted at a later edge, and is invisible to a lookup accepted at the same edge. The bench's driver queues the expected response when it presents a lookup. The monitor compares the response on the falling edge of each cycle in which the response is valid and ready, so every result is read exactly one cycle after its acceptance, or later by the length of a stall. Update-then-lookup pairs are always separated by at least one edge. The one same-edge pair is used on purpose to check the pre-update contents.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;

  // saturating history step
  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    ctr_t r;
    if (taken) r = (c == '1) ? c : ctr_t'(c + 1'b1);
    else       r = (c == '0) ? c : ctr_t'(c - 1'b1);
    return r;
  endfunction

  // upper half of the counter range predicts taken
  function automatic logic ctr_predict(ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0][ADDR_W-1:0] tgts,
  input  ctr_t [WAYS-1:0]             ctrs,
  input  logic [TAG_W-1:0]            tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output ctr_t                        ctr,
  output logic [ADDR_W-1:0]           target
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    ctr     = '0;
    target  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way = WAY_W'(w);
        ctr     = ctrs[w];
        target  = tgts[w];
      end
    end
  end
endmodule

// File: rtl/btb_lru_pick.sv
module btb_lru_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][WAY_W-1:0] ages,
  input  logic                       hit,
  input  logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim,
  output logic [WAYS-1:0][WAY_W-1:0] new_ages
);
  logic             found;
  logic [WAY_W-1:0] touch;

  // free way first (lowest index), else the oldest way
  always_comb begin
    found  = 1'b0;
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ages[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
      end
    end
  end

  assign touch = hit ? hit_way : victim;

  // touched way becomes youngest; younger ones age by one
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch)          new_ages[w] = '0;
      else if (ages[w] < ages[touch])  new_ages[w] = ages[w] + 1'b1;
      else                             new_ages[w] = ages[w];
    end
  end
endmodule

// File: rtl/btb_core.sv
module btb_core
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_target,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][ADDR_W-1:0] tgt_q   [SETS];
  ctr_t [WAYS-1:0]             ctr_q   [SETS];

  // lookup side
  logic [IDX_W-1:0]  l_idx;
  logic [WAYS-1:0]   l_hit_vec;
  logic              l_hit;
  logic [WAY_W-1:0]  l_way;
  ctr_t              l_ctr;
  logic [ADDR_W-1:0] l_tgt;
  logic              lk_fire;

  assign l_idx = lk_addr[IDX_W-1:0];

  btb_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_lk_look (
    .valid(valid_q[l_idx]), .tags(tag_q[l_idx]), .tgts(tgt_q[l_idx]),
    .ctrs(ctr_q[l_idx]), .tag(lk_addr[ADDR_W-1:IDX_W]),
    .hit_vec(l_hit_vec), .hit(l_hit), .hit_way(l_way),
    .ctr(l_ctr), .target(l_tgt)
  );

  // update side
  logic [IDX_W-1:0]           u_idx;
  logic [TAG_W-1:0]           u_tag;
  logic [WAYS-1:0]            u_hit_vec;
  logic                       u_hit;
  logic [WAY_W-1:0]           u_way;
  ctr_t                       u_ctr;
  logic [ADDR_W-1:0]          u_tgt;
  logic [WAY_W-1:0]           u_victim;
  logic [WAYS-1:0][WAY_W-1:0] u_new_ages;
  logic                       u_alloc;
  logic                       u_touch;

  assign u_idx = upd_addr[IDX_W-1:0];
  assign u_tag = upd_addr[ADDR_W-1:IDX_W];

  btb_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_up_look (
    .valid(valid_q[u_idx]), .tags(tag_q[u_idx]), .tgts(tgt_q[u_idx]),
    .ctrs(ctr_q[u_idx]), .tag(u_tag),
    .hit_vec(u_hit_vec), .hit(u_hit), .hit_way(u_way),
    .ctr(u_ctr), .target(u_tgt)
  );

  btb_lru_pick #(.WAYS(WAYS)) u_lru (
    .valid(valid_q[u_idx]), .ages(age_q[u_idx]),
    .hit(u_hit), .hit_way(u_way),
    .victim(u_victim), .new_ages(u_new_ages)
  );

  assign u_alloc = upd_valid && !u_hit && upd_taken;
  assign u_touch = upd_valid && (u_hit || upd_taken);

  // resettable state: valid flags and recency ranks
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (u_alloc) valid_q[u_idx][u_victim] <= 1'b1;
      if (u_touch) age_q[u_idx] <= u_new_ages;
    end
  end

  // payload: only meaningful behind a valid flag, so no reset
  always_ff @(posedge clk) begin
    if (!rst && upd_valid) begin
      if (u_hit) begin
        ctr_q[u_idx][u_way] <= ctr_next(u_ctr, upd_taken);
        if (upd_taken) tgt_q[u_idx][u_way] <= upd_target;
      end else if (upd_taken) begin
        tag_q[u_idx][u_victim] <= u_tag;
        tgt_q[u_idx][u_victim] <= upd_target;
        ctr_q[u_idx][u_victim] <= '1;
      end
    end
  end

  // response register with one-deep back-pressure
  assign lk_ready  = !rsp_valid || rsp_ready;
  assign lk_fire   = lk_valid && lk_ready;
  assign upd_ready = !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
    end else if (lk_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= l_hit;
      rsp_taken  <= l_hit && ctr_predict(l_ctr);
      rsp_target <= l_hit ? l_tgt : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  logic unused_u;
  assign unused_u = ^{u_tgt, l_way};
endmodule

// File: rtl/btb_core_chk.sv
module btb_core_chk #(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_taken,
  input logic [ADDR_W-1:0] rsp_target,
  input logic [WAYS-1:0]   l_hit_vec,
  input logic [WAYS-1:0]   u_hit_vec
);
  // R9
  one_way_lk_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(l_hit_vec));
  // R9
  one_way_up_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(u_hit_vec));
  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> !rsp_taken && rsp_target == '0);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit)
      && $stable(rsp_taken) && $stable(rsp_target));
  // R11
  rsp_due_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_ready |=> rsp_valid);
  // R11
  rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(lk_valid && lk_ready));
endmodule

bind btb_core btb_core_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_taken(rsp_taken), .rsp_target(rsp_target),
  .l_hit_vec(l_hit_vec), .u_hit_vec(u_hit_vec)
);

// File: tb/btb_core_bench.sv
`timescale 1ns/1ps
module btb_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_taken;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_addr = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int checks = 0;
  int errors = 0;

  logic [33:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  btb_core u_btb_core (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_target(rsp_target),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_addr(upd_addr),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one lookup, expectation queued for the monitor
  task automatic look(input logic [31:0] a, input logic h, input logic t,
                      input logic [31:0] tg, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    exp_q.push_back({h, t, tg});
    tag_q.push_back(req);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic upd(input logic [31:0] a, input logic t, input logic [31:0] tg);
    @(negedge clk);
    upd_valid  = 1'b1;
    upd_addr   = a;
    upd_taken  = t;
    upd_target = tg;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // monitor: pops one expectation per consumed response
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected response", 64'd1, 64'd0);
      end else begin
        logic [33:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(r, {30'd0, rsp_hit, rsp_taken, rsp_target}, {30'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R12 lk_ready after reset", {63'd0, lk_ready}, 64'd1);
    check("R12 upd_ready after reset", {63'd0, upd_ready}, 64'd1);
    look(32'h0024_6802, 0, 0, 32'h0, "R2 empty buffer miss");

    // mixed sequence across sets 0x02 and 0x04
    look(32'h0024_6802, 0, 0, 0, "R2 first"); upd(32'h0024_6802, 1, 32'hA000_0001);
    look(32'h0024_6804, 0, 0, 0, "R2 second"); upd(32'h0024_6804, 1, 32'hA000_0002);
    look(32'h0024_4202, 0, 0, 0, "R1 other tag same set"); upd(32'h0024_4202, 1, 32'hA000_0003);
    look(32'h0024_6802, 1, 1, 32'hA000_0001, "R4 allocated at 3"); upd(32'h0024_6802, 0, 32'h0);
    look(32'h0024_0202, 0, 0, 0, "R1 third tag miss"); upd(32'h0024_0202, 1, 32'hA000_0004);
    look(32'h0024_6802, 1, 1, 32'hA000_0001, "R3 counter 2 taken"); upd(32'h0024_6802, 0, 32'h0);
    look(32'h0024_4202, 1, 1, 32'hA000_0003, "R3 resident"); upd(32'h0024_4202, 1, 32'hA000_0003);
    look(32'h0024_6804, 1, 1, 32'hA000_0002, "R3 other set"); upd(32'h0024_6804, 1, 32'hA000_0002);
    look(32'h0024_6802, 1, 0, 32'hA000_0001, "R7 counter 1 not taken"); upd(32'h0024_6802, 0, 32'h0);
    look(32'h0024_6802, 1, 0, 32'hA000_0001, "R7 counter 0 target kept"); upd(32'h0024_6802, 1, 32'hA000_0001);
    look(32'h0024_6802, 1, 0, 32'hA000_0001, "R6 counter 1 not taken");

    // replacement in set 0x10
    upd(32'h0000_0110, 1, 32'hB1); upd(32'h0000_0210, 1, 32'hB2);
    upd(32'h0000_0310, 1, 32'hB3); upd(32'h0000_0410, 1, 32'hB4);
    look(32'h0000_0110, 1, 1, 32'hB1, "R8 free way kept A");
    look(32'h0000_0410, 1, 1, 32'hB4, "R8 free way kept D");
    upd(32'h0000_0110, 1, 32'hC1);
    upd(32'h0000_0510, 1, 32'hB5);
    look(32'h0000_0110, 1, 1, 32'hC1, "R6 target rewritten");
    look(32'h0000_0210, 0, 0, 0, "R8 LRU way evicted");
    look(32'h0000_0310, 1, 1, 32'hB3, "R8 C kept");
    look(32'h0000_0510, 1, 1, 32'hB5, "R8 new entry");
    upd(32'h0000_0610, 1, 32'hB6);
    look(32'h0000_0310, 0, 0, 0, "R8 next LRU evicted");
    look(32'h0000_0610, 1, 1, 32'hB6, "R8 F resident");
    look(32'h0000_0410, 1, 1, 32'hB4, "R8 D kept");

    // not-taken miss leaves buffer alone
    upd(32'h0000_0720, 0, 32'hD0);
    look(32'h0000_0720, 0, 0, 0, "R5 no allocation");

    // saturation at both ends
    upd(32'h0000_0830, 1, 32'hE0); upd(32'h0000_0830, 1, 32'hE0);
    upd(32'h0000_0830, 0, 32'h0);
    look(32'h0000_0830, 1, 1, 32'hE0, "R6 saturates at 3");
    upd(32'h0000_0830, 0, 32'h0); upd(32'h0000_0830, 0, 32'h0);
    upd(32'h0000_0830, 0, 32'h0); upd(32'h0000_0830, 1, 32'hE0);
    look(32'h0000_0830, 1, 0, 32'hE0, "R7 saturates at 0");
    upd(32'h0000_0830, 1, 32'hE0);
    look(32'h0000_0830, 1, 1, 32'hE0, "R6 climbs to 2");

    // same-edge lookup and update
    upd(32'h0000_0940, 1, 32'hF0); upd(32'h0000_0940, 0, 32'h0);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h0000_0940;
    upd_valid = 1'b1; upd_addr = 32'h0000_0940; upd_taken = 1'b0;
    exp_q.push_back({1'b1, 1'b1, 32'hF0}); tag_q.push_back("R10 pre-update view");
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    look(32'h0000_0940, 1, 0, 32'hF0, "R10 update landed");
    look(32'h0000_1940, 0, 0, 0, "R1 tag mismatch");

    // back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_addr = 32'h0000_0510;
    exp_q.push_back({1'b1, 1'b1, 32'hB5}); tag_q.push_back("R11 held response");
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R11 stall valid", {63'd0, rsp_valid}, 64'd1);
      check("R11 stall lk_ready", {63'd0, lk_ready}, 64'd0);
      @(negedge clk);
    end
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    @(negedge clk);

    // reset mid-run clears entries
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    look(32'h0024_6804, 0, 0, 0, "R12 entry cleared");
    look(32'h0000_0510, 0, 0, 0, "R12 entry cleared 2");
    repeat (3) @(negedge clk);
    check("R11 all responses seen", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule